// File: doc/BRIEF.md
# Sync Timing Measurement and ADC Calibration Pulse Unit

This block sits on the horizontal and vertical sync inputs of a digitized RGB stream and runs on the sample clock. It works out which level of each sync is the active pulse, which is the shorter of the two levels. It also measures the frame geometry: sample clocks per line and lines per frame. These results are published on status outputs once per frame, so that an external controller can identify the incoming video mode. If a sync input stops toggling, a no-signal flag is raised.

The block also drives two calibration pulses for the analog front end, a clamp pulse and a gain-correction pulse. Each has its own start offset and length in sample clocks. Both are counted from the trailing edge of every horizontal sync pulse, which is the edge that ends the active level. The clamp pulse has a selectable active level. The gain pulse is always active high.

Top module: `sync_timing_meas`

## Requirements
- R1: `hs_pos_o` is 1 when the high level of the horizontal sync lasts fewer clocks than its low level (active-high pulse), and 0 otherwise; it resets to 0.
- R2: `vs_pos_o` is 1 when the high level of the vertical sync spans fewer horizontal leading edges than its low level, and 0 otherwise; it resets to 0.
- R3: `h_total_o` reports the number of sample clocks from one horizontal leading edge (start of the active level) to the next, saturating at 2^CNT_W-1.
- R4: `v_total_o` reports the number of horizontal leading edges from one vertical leading edge up to the next; an edge in the same clock as the first vertical edge counts, one in the same clock as the second does not.
- R5: The four status outputs change only at a vertical leading edge. The first such edge after reset only arms the unit. All of them reset to 0, and a line length that is in progress is never published.
- R6: `no_sync_o` is set once the horizontal sync has had no edge for 2^TIMEOUT_W-1 clocks, or once the vertical sync has seen 2^TIMEOUT_W-1 horizontal leading edges with no edge of its own. It clears on the clock after the edge that ends the idle condition.
- R7: Let k be 0 for the output value registered at the clock that samples a horizontal trailing edge, increasing by one each clock and saturating at 2^(PULSE_W+1)-1. The clamp pulse is active for `clamp_start_i <= k < clamp_start_i + clamp_len_i`, and a length of 0 gives no pulse.
- R8: With `clamp_pol_i` = 1 the active clamp level is 1; with 0 it is 0 and the idle level is 1.
- R9: `gain_o` is 1 exactly for `gain_start_i <= k < gain_start_i + gain_len_i`, with k as in R7, and it is 0 otherwise.
- R10: From the first clock after reset until the first horizontal trailing edge, both pulses stay at their idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, either polarity |
| vsync_i | input | 1 | Vertical sync, either polarity |
| clamp_start_i | input | PULSE_W | Clamp pulse offset after the horizontal trailing edge |
| clamp_len_i | input | PULSE_W | Clamp pulse length in clocks |
| clamp_pol_i | input | 1 | Clamp active level (1 = high) |
| gain_start_i | input | PULSE_W | Gain pulse offset after the horizontal trailing edge |
| gain_len_i | input | PULSE_W | Gain pulse length in clocks |
| clamp_o | output | 1 | Clamp calibration pulse |
| gain_o | output | 1 | Gain-correction pulse, active high |
| h_total_o | output | CNT_W | Clocks per line |
| v_total_o | output | CNT_W | Lines per frame |
| hs_pos_o | output | 1 | Horizontal sync is active high |
| vs_pos_o | output | 1 | Vertical sync is active high |
| no_sync_o | output | 1 | Sync lost |

## Verification
The bench builds the unit with CNT_W = 8, TIMEOUT_W = 9 and PULSE_W kept at 11. With the narrower count, a 300-clock line reaches the saturation limit of the line counter, and the shorter timeout lets the loss-of-sync flag set and clear within a few hundred clocks. The full pulse width still lets the calibration windows sit anywhere in short lines. Frames with both sync polarities, random line lengths, random pulse widths and random pulse windows run alongside directed cases: a zero-length pulse, a pulse at offset zero, a line-length change caught mid-frame, and the first-frame arming.

// File: rtl/sync_meas_pkg.sv
package sync_meas_pkg;

    // Which level of a signal carries the active pulse.
    typedef enum logic {
        ACT_LOW  = 1'b0,
        ACT_HIGH = 1'b1
    } act_level_e;

endpackage

// File: rtl/sync_edge_track.sv
module sync_edge_track
    import sync_meas_pkg::*;
#(
    parameter int RUN_W = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sync_i,
    input  logic       tick_i,
    output logic       lead_o,
    output logic       trail_o,
    output act_level_e act_o,
    output logic       stale_o
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic             lvl;
        act_level_e       act;
        logic [RUN_W-1:0] run;
        logic [RUN_W-1:0] hi_len;
    } trk_t;

    trk_t trk_d, trk_q;
    logic rise, fall;

    always_comb begin
        trk_d     = trk_q;
        rise      = sync_i & ~trk_q.lvl;
        fall      = ~sync_i & trk_q.lvl;
        trk_d.lvl = sync_i;
        if (rise || fall) begin
            trk_d.run = {{(RUN_W-1){1'b0}}, tick_i};
        end else if (tick_i && (trk_q.run != RUN_MAX)) begin
            trk_d.run = trk_q.run + 1'b1;
        end
        if (fall) begin
            trk_d.hi_len = trk_q.run;
        end
        if (rise) begin
            // Compare the finished high time with the finished low time.
            trk_d.act = (trk_q.hi_len < trk_q.run) ? ACT_HIGH : ACT_LOW;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trk_q <= '{lvl: 1'b0, act: ACT_LOW, run: '0, hi_len: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign lead_o  = (trk_q.act == ACT_HIGH) ? rise : fall;
    assign trail_o = (trk_q.act == ACT_HIGH) ? fall : rise;
    assign act_o   = trk_q.act;
    assign stale_o = (trk_q.run == RUN_MAX);

endmodule

// File: rtl/frame_measure.sv
module frame_measure
    import sync_meas_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hs_lead_i,
    input  logic             vs_lead_i,
    input  act_level_e       hs_act_i,
    input  act_level_e       vs_act_i,
    output logic [CNT_W-1:0] h_total_o,
    output logic [CNT_W-1:0] v_total_o,
    output logic             hs_pos_o,
    output logic             vs_pos_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] hcnt;
        logic [CNT_W-1:0] line_len;
        logic [CNT_W-1:0] vcnt;
        logic             armed;
        logic [CNT_W-1:0] h_total;
        logic [CNT_W-1:0] v_total;
        logic             hs_pos;
        logic             vs_pos;
    } meas_t;

    meas_t m_d, m_q;
    logic [CNT_W-1:0] done_line;

    always_comb begin
        m_d       = m_q;
        done_line = hs_lead_i ? m_q.hcnt : m_q.line_len;

        if (hs_lead_i) begin
            m_d.line_len = m_q.hcnt;
            m_d.hcnt     = {{(CNT_W-1){1'b0}}, 1'b1};
        end else if (m_q.hcnt != CNT_MAX) begin
            m_d.hcnt = m_q.hcnt + 1'b1;
        end

        if (vs_lead_i) begin
            m_d.vcnt  = {{(CNT_W-1){1'b0}}, hs_lead_i};
            m_d.armed = 1'b1;
            if (m_q.armed) begin
                m_d.h_total = done_line;
                m_d.v_total = m_q.vcnt;
                m_d.hs_pos  = (hs_act_i == ACT_HIGH);
                m_d.vs_pos  = (vs_act_i == ACT_HIGH);
            end
        end else if (hs_lead_i && (m_q.vcnt != CNT_MAX)) begin
            m_d.vcnt = m_q.vcnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign h_total_o = m_q.h_total;
    assign v_total_o = m_q.v_total;
    assign hs_pos_o  = m_q.hs_pos;
    assign vs_pos_o  = m_q.vs_pos;

endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen
    import sync_meas_pkg::*;
#(
    parameter int PULSE_W = 11
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               restart_i,
    input  logic [PULSE_W-1:0] start_i,
    input  logic [PULSE_W-1:0] len_i,
    input  act_level_e         act_i,
    output logic               pulse_o
);
    localparam int CW = PULSE_W + 1;
    localparam logic [CW-1:0] POS_MAX = '1;

    typedef struct packed {
        logic [CW-1:0] pos;
        logic          out;
    } pg_t;

    pg_t pg_d, pg_q;
    logic [CW-1:0] win_lo, win_hi;
    logic in_win;

    always_comb begin
        pg_d = pg_q;
        if (restart_i) begin
            pg_d.pos = '0;
        end else if (pg_q.pos != POS_MAX) begin
            pg_d.pos = pg_q.pos + 1'b1;
        end
        win_lo = CW'(start_i);
        win_hi = CW'(start_i) + CW'(len_i);
        in_win = (pg_d.pos >= win_lo) && (pg_d.pos < win_hi);
        pg_d.out = (act_i == ACT_HIGH) ? in_win : ~in_win;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pg_q <= '{pos: POS_MAX, out: 1'b0};
        end else begin
            pg_q <= pg_d;
        end
    end

    assign pulse_o = pg_q.out;

endmodule

// File: rtl/sync_timing_meas.sv
module sync_timing_meas
    import sync_meas_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int TIMEOUT_W = 16,
    parameter int PULSE_W   = 11
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               hsync_i,
    input  logic               vsync_i,
    input  logic [PULSE_W-1:0] clamp_start_i,
    input  logic [PULSE_W-1:0] clamp_len_i,
    input  logic               clamp_pol_i,
    input  logic [PULSE_W-1:0] gain_start_i,
    input  logic [PULSE_W-1:0] gain_len_i,
    output logic               clamp_o,
    output logic               gain_o,
    output logic [CNT_W-1:0]   h_total_o,
    output logic [CNT_W-1:0]   v_total_o,
    output logic               hs_pos_o,
    output logic               vs_pos_o,
    output logic               no_sync_o
);
    localparam int NUM_PULSES = 2;

    logic       hs_lead, hs_trail, hs_stale;
    logic       vs_lead, vs_trail, vs_stale;
    act_level_e hs_act, vs_act;

    // Horizontal sync: idle time counted in sample clocks.
    sync_edge_track #(.RUN_W(TIMEOUT_W)) u_hs_trk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sync_i  (hsync_i),
        .tick_i  (1'b1),
        .lead_o  (hs_lead),
        .trail_o (hs_trail),
        .act_o   (hs_act),
        .stale_o (hs_stale)
    );

    // Vertical sync: level lengths and idle time counted in lines.
    sync_edge_track #(.RUN_W(TIMEOUT_W)) u_vs_trk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sync_i  (vsync_i),
        .tick_i  (hs_lead),
        .lead_o  (vs_lead),
        .trail_o (vs_trail),
        .act_o   (vs_act),
        .stale_o (vs_stale)
    );

    frame_measure #(.CNT_W(CNT_W)) u_meas (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hs_lead_i (hs_lead),
        .vs_lead_i (vs_lead),
        .hs_act_i  (hs_act),
        .vs_act_i  (vs_act),
        .h_total_o (h_total_o),
        .v_total_o (v_total_o),
        .hs_pos_o  (hs_pos_o),
        .vs_pos_o  (vs_pos_o)
    );

    logic [NUM_PULSES-1:0][PULSE_W-1:0] p_start, p_len;
    act_level_e                         p_act [NUM_PULSES];
    logic [NUM_PULSES-1:0]              p_out;

    assign p_start  = {gain_start_i, clamp_start_i};
    assign p_len    = {gain_len_i, clamp_len_i};
    assign p_act[0] = act_level_e'(clamp_pol_i);
    assign p_act[1] = ACT_HIGH;

    for (genvar gi = 0; gi < NUM_PULSES; gi++) begin : g_pulse
        cal_pulse_gen #(.PULSE_W(PULSE_W)) u_pulse (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .restart_i (hs_trail),
            .start_i   (p_start[gi]),
            .len_i     (p_len[gi]),
            .act_i     (p_act[gi]),
            .pulse_o   (p_out[gi])
        );
    end

    assign clamp_o   = p_out[0];
    assign gain_o    = p_out[1];
    assign no_sync_o = hs_stale | vs_stale;

    // The vertical trailing edge has no consumer.
    logic vs_trail_unused;
    assign vs_trail_unused = vs_trail;

endmodule

// File: rtl/sync_timing_meas_chk.sv
module sync_timing_meas_chk #(
    parameter int CNT_W   = 12,
    parameter int PULSE_W = 11
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               hsync_i,
    input logic               hs_lead,
    input logic               hs_trail,
    input logic               hs_stale,
    input logic               vs_lead,
    input logic [CNT_W-1:0]   h_total_o,
    input logic [CNT_W-1:0]   v_total_o,
    input logic [PULSE_W-1:0] clamp_len_i,
    input logic               clamp_pol_i,
    input logic               clamp_o,
    input logic [PULSE_W-1:0] gain_len_i,
    input logic               gain_o
);

    // R3: a clock can start a line or end its active pulse, not both
    a_r3_lead_trail_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({hs_lead, hs_trail}));

    // R5: status holds between vertical leading edges
    a_r5_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vs_lead |=> ($stable(h_total_o) && $stable(v_total_o)));

    // R6: an edge on the horizontal sync ends the idle condition
    a_r6_edge_clears_stale: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hsync_i != $past(hsync_i)) |=> !hs_stale);

    // R9: a zero gain length gives no gain pulse
    a_r9_gain_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gain_len_i == '0) |=> !gain_o);

    // R8: a zero clamp length leaves the clamp at its idle level
    a_r8_clamp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clamp_len_i == '0) |=> (clamp_o == !$past(clamp_pol_i)));

endmodule

bind sync_timing_meas sync_timing_meas_chk #(
    .CNT_W   (CNT_W),
    .PULSE_W (PULSE_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hsync_i     (hsync_i),
    .hs_lead     (hs_lead),
    .hs_trail    (hs_trail),
    .hs_stale    (hs_stale),
    .vs_lead     (vs_lead),
    .h_total_o   (h_total_o),
    .v_total_o   (v_total_o),
    .clamp_len_i (clamp_len_i),
    .clamp_pol_i (clamp_pol_i),
    .clamp_o     (clamp_o),
    .gain_len_i  (gain_len_i),
    .gain_o      (gain_o)
);

// File: tb/test_sync_timing_meas.sv
`timescale 1ns/100ps
module test_sync_timing_meas;
    localparam int CNT_W     = 8;
    localparam int TIMEOUT_W = 9;
    localparam int PULSE_W   = 11;
    localparam int CNT_SAT   = (1 << CNT_W) - 1;
    localparam int K_SAT     = (1 << (PULSE_W + 1)) - 1;
    localparam int IDLE_LIM  = (1 << TIMEOUT_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0, hs = 1'b0, vs = 1'b0;
    logic [PULSE_W-1:0] c_start = '0, c_len = '0, g_start = '0, g_len = '0;
    logic c_pol = 1'b1;
    logic clamp, gain, hs_pos, vs_pos, no_sync;
    logic [CNT_W-1:0] h_total, v_total;

    int n_cmp = 0, n_bad = 0;
    int k_trail = K_SAT;
    bit chk_pulse = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sync_timing_meas #(.CNT_W(CNT_W), .TIMEOUT_W(TIMEOUT_W), .PULSE_W(PULSE_W)) i_sync_timing_meas (
        .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs),
        .clamp_start_i(c_start), .clamp_len_i(c_len), .clamp_pol_i(c_pol),
        .gain_start_i(g_start), .gain_len_i(g_len),
        .clamp_o(clamp), .gain_o(gain), .h_total_o(h_total), .v_total_o(v_total),
        .hs_pos_o(hs_pos), .vs_pos_o(vs_pos), .no_sync_o(no_sync)
    );

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int in_win(int k, int s, int l);
        return (k >= s && k < s + l) ? 1 : 0;
    endfunction

    // One sample clock: drive at the falling edge, observe one clock later.
    task automatic tick(logic h, logic v, logic hp);
        bit was_act;
        was_act = (hs == hp);
        hs = h;
        vs = v;
        @(posedge clk);
        @(negedge clk);
        if (was_act && (h != hp)) k_trail = 0;
        else if (k_trail < K_SAT) k_trail++;
        if (chk_pulse) begin
            check("R7 R8 clamp", int'(clamp),
                  c_pol ? in_win(k_trail, c_start, c_len) : 1 - in_win(k_trail, c_start, c_len));
            check("R9 gain", int'(gain), in_win(k_trail, g_start, g_len));
        end
    endtask

    task automatic run_frame(int p, int w, int l, int vw, logic hp, logic vp, int nlines);
        for (int ln = 0; ln < nlines; ln++) begin
            for (int c = 0; c < p; c++) begin
                bit ha, va;
                ha = (c < w);
                va = (ln == 0 && c >= p / 2) || (ln > 0 && ln < vw) || (ln == vw && c < p / 2);
                tick(ha ? hp : !hp, va ? vp : !vp, hp);
            end
        end
    endtask

    task automatic scenario(int p, int w, int l, int vw, logic hp, logic vp,
                            int cs, int cl, logic cp, int gs, int gl);
        c_start = PULSE_W'(cs); c_len = PULSE_W'(cl); c_pol = cp;
        g_start = PULSE_W'(gs); g_len = PULSE_W'(gl);
        for (int f = 0; f < 3; f++) run_frame(p, w, l, vw, hp, vp, l);
        chk_pulse = 1'b1;
        run_frame(p, w, l, vw, hp, vp, l);
        chk_pulse = 1'b0;
        check("R3 line length", int'(h_total), (p > CNT_SAT) ? CNT_SAT : p);
        check("R4 lines per frame", int'(v_total), l);
        check("R1 hsync polarity", int'(hs_pos), int'(hp));
        check("R2 vsync polarity", int'(vs_pos), int'(vp));
        check("R6 no loss while active", int'(no_sync), 0);
    endtask

    initial begin
        void'($urandom(32'd7351));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) tick(1'b0, 1'b0, 1'b1);
        // Reset state
        check("R5 reset h_total", int'(h_total), 0);
        check("R5 reset v_total", int'(v_total), 0);
        check("R1 reset", int'(hs_pos), 0);
        check("R2 reset", int'(vs_pos), 0);
        check("R6 reset", int'(no_sync), 0);
        check("R10 clamp idle", int'(clamp), 0);
        check("R10 gain idle", int'(gain), 0);

        // First vertical leading edge only arms the unit
        run_frame(40, 4, 12, 2, 1'b0, 1'b0, 12);
        check("R5 first frame not published", int'(h_total), 0);
        check("R5 first frame not published v", int'(v_total), 0);

        // Directed corners: both polarities, zero length, start at zero
        scenario(40, 4, 12, 2, 1'b1, 1'b1, 0, 5, 1'b1, 3, 0);
        scenario(40, 4, 12, 2, 1'b0, 1'b0, 2, 0, 1'b0, 0, 1);
        scenario(64, 30, 20, 3, 1'b1, 1'b0, 5, 10, 1'b0, 12, 7);

        // Line length change seen mid-frame must not be published yet
        scenario(40, 4, 12, 2, 1'b1, 1'b1, 1, 3, 1'b1, 4, 4);
        run_frame(50, 5, 12, 2, 1'b1, 1'b1, 6);
        check("R5 mid-frame hold h", int'(h_total), 40);
        check("R5 mid-frame hold v", int'(v_total), 12);
        scenario(50, 5, 12, 2, 1'b1, 1'b1, 6, 6, 1'b1, 0, 2);

        // Saturating line counter
        scenario(300, 10, 6, 1, 1'b0, 1'b1, 19, 14, 1'b0, 8, 9);

        // Random frames
        for (int i = 0; i < 6; i++) begin
            int p, w, l, vw;
            p  = 32 + int'($urandom % 60);
            w  = 1 + int'($urandom % (p / 2 - 1));
            l  = 8 + int'($urandom % 10);
            vw = 1 + int'($urandom % ((l - 1) / 2));
            scenario(p, w, l, vw, logic'($urandom % 2), logic'($urandom % 2),
                     int'($urandom % 20), int'($urandom % 15), logic'($urandom % 2),
                     int'($urandom % 20), int'($urandom % 15));
        end

        // Loss of horizontal sync
        tick(1'b1, vs, 1'b1);
        tick(1'b0, vs, 1'b1);
        repeat (IDLE_LIM - 6) tick(1'b0, vs, 1'b1);
        check("R6 not yet idle", int'(no_sync), 0);
        repeat (10) tick(1'b0, vs, 1'b1);
        check("R6 idle detected", int'(no_sync), 1);
        tick(1'b1, vs, 1'b1);
        check("R6 cleared by edge", int'(no_sync), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule